// File: doc/BRIEF.md
# Slotted ON-OFF Cell Generator

This block produces a synthetic stream of cell arrivals for loading a reassembly or merging stage under test. Time advances in slots, one per enabled clock. In each slot the block either emits one cell or stays idle. It alternates between idle OFF periods and ON periods. Each ON period carries exactly one packet, and the last cell of that packet is flagged.

OFF lengths and packet lengths are geometric. Each is controlled by a per-slot or per-cell probability given as a 16-bit fraction, so the mean is 65536 divided by the threshold. A shaped, slower source is modelled by stretching the ON period. Each ON slot carries a cell only when a Bernoulli draw at the source rate succeeds. The end-of-packet draw is taken only on slots that really emit a cell, so the mean packet size does not depend on the rate. A full-rate input sends the cells of a packet back to back.

Two 16-bit LFSRs supply all random draws. The stream is therefore fully repeatable from the seed.

Top module: `onoff_cell_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters the OFF state. It clears `cell_valid`, `cell_sop` and `cell_eop`, clears `cell_tag` to 0, and loads draw source A with 16'hACE1 and draw source B with its bitwise complement 16'h531E.
- R2: Each draw source is a right-shifting Galois LFSR with feedback mask 16'hB400. A step maps x to (x>>1) XOR 16'hB400 when x[0] is 1, and to x>>1 otherwise. Both sources step exactly once per slot, and a slot's decisions use the values held before that step.
- R3: In the OFF state every slot is idle. An OFF slot moves the block into ON when A < `p_start`. This gives at least one idle slot after each packet.
- R4: An ON slot emits a cell when `full_rate` is 1, or when B < `p_rate`. Otherwise the slot is idle and the block stays ON. With `full_rate` set, the cells of a packet occupy consecutive slots.
- R5: Each emitted cell is the last cell of its packet when A < `p_last`. The last cell is flagged with `cell_eop`, and the next slot is in the OFF state.
- R6: The first cell emitted in an ON period carries `cell_sop`. `cell_sop` and `cell_eop` are never 1 without `cell_valid`. A one-cell packet raises both flags in the same slot.
- R7: `cell_tag` increments by one, wrapping modulo 2^TAG_W, in the slot that carries `cell_sop`. It holds its value in every other slot, so the tag stays the same on every cell of a packet. The first packet after reset has tag 1.
- R8: A clock edge with `en` low is not a slot. The state, the tag and both draw sources hold, and the outputs of that cycle are idle.
- R9: A clock edge with `seed_load` high is not a slot, whatever the value of `en`, and its outputs are idle. It loads A with `seed` and B with ~`seed`; a value of zero is replaced by 16'h0001.
- R10: Outputs are registered. The decisions of the slot taken at a clock edge appear on the outputs just after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Slot enable; when low, the generator state freezes |
| seed_load | input | 1 | Load both draw sources from `seed` |
| seed | input | 16 | Seed value for draw source A; B takes its complement |
| full_rate | input | 1 | Source rate of 1: cells of a packet are back to back |
| p_rate | input | 16 | Per-slot cell probability in ON when not at full rate |
| p_start | input | 16 | Per-slot probability of leaving OFF |
| p_last | input | 16 | Per-cell probability that the cell ends its packet |
| cell_valid | output | 1 | The slot carries a cell |
| cell_sop | output | 1 | The cell is the first of its packet |
| cell_eop | output | 1 | The cell is the last of its packet |
| cell_tag | output | TAG_W | Packet sequence tag of the cell |

## Verification
The first and the last cell of a packet can be the same cell. A start and an end of packet then fall in one slot, and that same slot also advances the tag. The bench provokes this by setting `p_last` to all ones, which makes almost every packet one cell long. It runs this case long enough for the tag to wrap past 255 to 0 on such a slot. The reference model advances its own LFSR copies and predicts the exact slot where the flags coincide. The bench compares valid, both flags and the tag on every clock. It also counts the one-cell packets and checks that a wrap to tag 0 was seen.

// File: rtl/cellgen_pkg.sv
// Package: shared constants and the slot state type of the cell generator.
// Assumes: all probabilities are unsigned fractions of 2^PROB_W.
package cellgen_pkg;

    localparam int unsigned PROB_W = 16;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,   // idle slots, waiting for the start draw
        ST_HEAD = 2'd1,   // ON, no cell of the packet emitted yet
        ST_BODY = 2'd2    // ON, at least one cell already emitted
    } slot_state_e;

endpackage

// File: rtl/cellgen_lfsr.sv
// Module: one draw source, a right-shifting Galois LFSR.
// Assumes: TAPS describes a maximal-length polynomial. The all-zero state is
// never entered, because a zero load or reset value is replaced by 1.
module cellgen_lfsr #(
    parameter int unsigned   W    = 16,
    parameter logic [W-1:0]  TAPS = 16'hB400,
    parameter logic [W-1:0]  SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] state
);

    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] SEED_SAFE = (SEED == '0) ? ONE : SEED;

    logic [W-1:0] load_safe;
    logic [W-1:0] stepped;

    // Replace a zero seed and form the next LFSR value.
    always_comb begin
        load_safe = (load_val == '0) ? ONE : load_val;
        stepped   = (state >> 1) ^ ({W{state[0]}} & TAPS);
    end

    // Hold, load or advance the LFSR state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED_SAFE;
        end else if (load) begin
            state <= load_safe;
        end else if (step) begin
            state <= stepped;
        end
    end

endmodule

// File: rtl/cellgen_slot_fsm.sv
// Module: per-slot ON/OFF control, cell emission and the packet tag.
// Assumes: draw_a and draw_b are fresh random values for the current slot.
// slot_en low means this edge is not a slot: the state holds and the outputs
// go idle.
module cellgen_slot_fsm
    import cellgen_pkg::*;
#(
    parameter int unsigned PW    = 16,
    parameter int unsigned TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_en,
    input  logic             full_rate,
    input  logic [PW-1:0]    p_start,
    input  logic [PW-1:0]    p_rate,
    input  logic [PW-1:0]    p_last,
    input  logic [PW-1:0]    draw_a,
    input  logic [PW-1:0]    draw_b,
    output logic             cell_valid,
    output logic             cell_sop,
    output logic             cell_eop,
    output logic [TAG_W-1:0] cell_tag
);

    slot_state_e state_q;
    slot_state_e state_d;
    logic        start_hit;
    logic        last_hit;
    logic        rate_hit;
    logic        emit;
    logic        first;

    // Evaluate the draws of this slot against the thresholds.
    always_comb begin
        start_hit = (draw_a < p_start);
        last_hit  = (draw_a < p_last);
        rate_hit  = full_rate || (draw_b < p_rate);
        emit      = (state_q != ST_OFF) && rate_hit;
        first     = (state_q == ST_HEAD);
    end

    // Choose the state of the next slot.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_OFF:           if (start_hit) state_d = ST_HEAD;
            ST_HEAD, ST_BODY: if (rate_hit)  state_d = last_hit ? ST_OFF : ST_BODY;
            default:          state_d = ST_OFF;
        endcase
    end

    // Register the state, the slot outputs and the packet tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_OFF;
            cell_valid <= 1'b0;
            cell_sop   <= 1'b0;
            cell_eop   <= 1'b0;
            cell_tag   <= '0;
        end else if (!slot_en) begin
            cell_valid <= 1'b0;
            cell_sop   <= 1'b0;
            cell_eop   <= 1'b0;
        end else begin
            state_q    <= state_d;
            cell_valid <= emit;
            cell_sop   <= emit && first;
            cell_eop   <= emit && last_hit;
            if (emit && first) begin
                cell_tag <= cell_tag + 1'b1;
            end
        end
    end

endmodule

// File: rtl/onoff_cell_gen.sv
// Module: top of the slotted ON-OFF cell generator.
// Assumes: one slot per clock with en high and seed_load low. Source A drives
// the start and last draws, source B drives the rate draw.
module onoff_cell_gen
    import cellgen_pkg::*;
#(
    parameter int unsigned        TAG_W        = 8,
    parameter logic [PROB_W-1:0]  DEFAULT_SEED = 16'hACE1,
    parameter logic [PROB_W-1:0]  LFSR_TAPS    = 16'hB400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              seed_load,
    input  logic [PROB_W-1:0] seed,
    input  logic              full_rate,
    input  logic [PROB_W-1:0] p_rate,
    input  logic [PROB_W-1:0] p_start,
    input  logic [PROB_W-1:0] p_last,
    output logic              cell_valid,
    output logic              cell_sop,
    output logic              cell_eop,
    output logic [TAG_W-1:0]  cell_tag
);

    localparam int unsigned NUM_SRC = 2;

    logic              slot_en;
    logic [PROB_W-1:0] draw [NUM_SRC];

    // A slot happens on an enabled edge that is not a seed load.
    always_comb slot_en = en && !seed_load;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        localparam logic [PROB_W-1:0] SRC_SEED = (g == 0) ? DEFAULT_SEED : ~DEFAULT_SEED;
        logic [PROB_W-1:0] ld_val;

        // Source 0 takes the seed and source 1 takes its complement.
        always_comb ld_val = (g == 0) ? seed : ~seed;

        cellgen_lfsr #(
            .W    (PROB_W),
            .TAPS (LFSR_TAPS),
            .SEED (SRC_SEED)
        ) u_lfsr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (seed_load),
            .load_val (ld_val),
            .step     (slot_en),
            .state    (draw[g])
        );
    end

    cellgen_slot_fsm #(
        .PW    (PROB_W),
        .TAG_W (TAG_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_en    (slot_en),
        .full_rate  (full_rate),
        .p_start    (p_start),
        .p_rate     (p_rate),
        .p_last     (p_last),
        .draw_a     (draw[0]),
        .draw_b     (draw[1]),
        .cell_valid (cell_valid),
        .cell_sop   (cell_sop),
        .cell_eop   (cell_eop),
        .cell_tag   (cell_tag)
    );

endmodule

// File: rtl/onoff_cell_gen_chk.sv
// Module: property checker for the cell generator, attached by bind.
// Assumes: it only observes the top-level ports of onoff_cell_gen.
module onoff_cell_gen_chk #(
    parameter int unsigned TAG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             seed_load,
    input logic             full_rate,
    input logic             cell_valid,
    input logic             cell_sop,
    input logic             cell_eop,
    input logic [TAG_W-1:0] cell_tag
);

    localparam logic [TAG_W-1:0] TAG_ONE = {{(TAG_W-1){1'b0}}, 1'b1};

    logic             in_pkt;
    logic [TAG_W-1:0] tag_q;
    logic [TAG_W-1:0] tag_q_inc;

    // Track packet framing and the previous tag, seen from the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt <= 1'b0;
            tag_q  <= '0;
        end else begin
            tag_q <= cell_tag;
            if (cell_valid && cell_eop)      in_pkt <= 1'b0;
            else if (cell_valid && cell_sop) in_pkt <= 1'b1;
        end
    end

    // Expected tag value at a start of packet.
    always_comb tag_q_inc = tag_q + TAG_ONE;

    assert_flags_need_cell_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_sop || cell_eop) |-> cell_valid);

    assert_sop_outside_pkt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cell_sop |-> !in_pkt);

    assert_body_inside_pkt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_valid && !cell_sop) |-> in_pkt);

    assert_gap_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_valid && cell_eop) |=> !cell_valid);

    assert_back_to_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !seed_load && full_rate && cell_valid && !cell_eop) |=> cell_valid);

    assert_idle_when_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !cell_valid);

    assert_seed_edge_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> !cell_valid);

    assert_tag_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cell_sop |-> (cell_tag == tag_q_inc));

    assert_tag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_sop |-> (cell_tag == tag_q));

endmodule

bind onoff_cell_gen onoff_cell_gen_chk #(.TAG_W(TAG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .seed_load  (seed_load),
    .full_rate  (full_rate),
    .cell_valid (cell_valid),
    .cell_sop   (cell_sop),
    .cell_eop   (cell_eop),
    .cell_tag   (cell_tag)
);

// File: tb/onoff_cell_gen_tb.sv
`timescale 1ns/1ps
// Bench: behavioural slot model compared against the outputs on every clock.
module onoff_cell_gen_tb;

    localparam int TAG_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             seed_load = 1'b0;
    logic [15:0]      seed = 16'h0;
    logic             full_rate = 1'b1;
    logic [15:0]      p_rate = 16'h0;
    logic [15:0]      p_start = 16'h4000;
    logic [15:0]      p_last = 16'h2000;
    logic             cell_valid;
    logic             cell_sop;
    logic             cell_eop;
    logic [TAG_W-1:0] cell_tag;

    int tests = 0;
    int fails = 0;

    onoff_cell_gen #(.TAG_W(TAG_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .seed_load(seed_load), .seed(seed),
        .full_rate(full_rate), .p_rate(p_rate), .p_start(p_start), .p_last(p_last),
        .cell_valid(cell_valid), .cell_sop(cell_sop), .cell_eop(cell_eop),
        .cell_tag(cell_tag)
    );

    always #4 clk = ~clk;

    // Reference model state: draw sources, phase (0 OFF, 1 ON no cell yet, 2 ON), tag.
    logic [15:0] ma, mb;
    int          mphase = 0;
    int          mtag = 0;
    bit          ev = 0, es = 0, ee = 0;

    function automatic logic [15:0] lfsr_next(input logic [15:0] x);
        return x[0] ? ((x >> 1) ^ 16'hB400) : (x >> 1);
    endfunction

    function automatic logic [15:0] nz(input logic [15:0] x);
        return (x == 16'h0) ? 16'h0001 : x;
    endfunction

    // Model update at each edge, from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            ma = 16'hACE1; mb = 16'h531E; mphase = 0; mtag = 0;
            ev = 0; es = 0; ee = 0;
        end else if (seed_load) begin
            ma = nz(seed); mb = nz(~seed);
            ev = 0; es = 0; ee = 0;
        end else if (!en) begin
            ev = 0; es = 0; ee = 0;
        end else begin
            ev = 0; es = 0; ee = 0;
            if (mphase == 0) begin
                if (ma < p_start) mphase = 1;
            end else if (full_rate || (mb < p_rate)) begin
                ev = 1;
                es = (mphase == 1);
                ee = (ma < p_last);
                if (es) mtag = (mtag + 1) % (1 << TAG_W);
                mphase = ee ? 0 : 2;
            end
            ma = lfsr_next(ma);
            mb = lfsr_next(mb);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    bit prev_eop = 0;
    bit in_pkt = 0;
    int pkts = 0, gaps = 0, singles = 0, wraps = 0;

    // One slot: wait for the edge, then compare at the falling edge.
    task automatic slot(input string ph);
        bit en_edge;
        bit ld_edge;
        en_edge = en;
        ld_edge = seed_load;
        @(negedge clk);
        check(cell_valid == ev, "R4", {ph, " valid"}, cell_valid, ev);
        check(cell_sop == es,   "R6", {ph, " sop"},   cell_sop, es);
        check(cell_eop == ee,   "R5", {ph, " eop"},   cell_eop, ee);
        check(int'(cell_tag) == mtag, "R7", {ph, " tag"}, cell_tag, mtag);
        if (prev_eop) check(!cell_valid, "R3", {ph, " idle after last"}, cell_valid, 0);
        if (!en_edge) check(!cell_valid, "R8", {ph, " frozen slot"}, cell_valid, 0);
        if (ld_edge)  check(!cell_valid, "R9", {ph, " seed edge"}, cell_valid, 0);
        if (cell_valid && cell_sop) begin
            pkts++;
            if (cell_tag == '0) wraps++;
        end
        if (cell_valid && cell_sop && cell_eop) singles++;
        if (in_pkt && !cell_valid && en_edge && !ld_edge) gaps++;
        if (cell_valid && cell_eop) in_pkt = 0;
        else if (cell_valid && cell_sop) in_pkt = 1;
        prev_eop = cell_valid && cell_eop;
    endtask

    task automatic run(input int n, input string ph);
        for (int k = 0; k < n; k++) slot(ph);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R10: got hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        check(!cell_valid && !cell_sop && !cell_eop, "R1", "reset flags", cell_valid, 0);
        check(cell_tag == '0, "R1", "reset tag", cell_tag, 0);
        rst_n = 1'b1;
        en = 1'b1;

        // R4 full rate, R2 draw sequence under nominal thresholds.
        run(600, "R2 full-rate");
        check(pkts > 0, "R2", "packets at full rate", pkts, 1);
        check(gaps == 0, "R4", "gaps inside packets at full rate", gaps, 0);

        // Slow source: rate 0.2, stretched ON periods.
        full_rate = 1'b0; p_rate = 16'h3333; gaps = 0;
        run(1500, "R4 slow");
        check(gaps > 0, "R4", "idle slots inside slow packets", gaps, 1);

        // R8: enable toggling while slow.
        for (int k = 0; k < 600; k++) begin
            en = ((k % 5) < 3);
            slot("R8 gated");
        end
        en = 1'b1;

        // R9: seed loads, including zero, with en low on one of them.
        seed = 16'h0000; seed_load = 1'b1;
        slot("R9 seed0");
        seed_load = 1'b0;
        run(300, "R9 after seed0");
        seed = 16'h1234; seed_load = 1'b1; en = 1'b0;
        slot("R9 seed1234");
        seed_load = 1'b0; en = 1'b1;
        run(300, "R9 after seed1234");

        // R6/R7: one-cell packets, coincident sop and eop, tag wrap.
        full_rate = 1'b1; p_start = 16'hFFFF; p_last = 16'hFFFF; singles = 0; wraps = 0;
        run(700, "R6 single");
        check(singles > 0, "R6", "one-cell packets seen", singles, 1);
        check(wraps > 0, "R7", "tag wrap to 0 seen", wraps, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule